// File: doc/BRIEF.md
# Segment and Page Access Permission Checker

This block vets one memory access in two pipelined steps. In the first step it applies segmentation rules to the incoming virtual address. These rules cover the null-selector check, the read and write permission of code and data segments, and a two-ended limit check that works for both normal and expand-down segments. The same step forms the linear address and truncates it to 32 bits when the machine is not in 64-bit mode or when the address-size override is set. The registered linear address is handed to a translation buffer outside this block.

In the second step the block takes the attributes of the translation-buffer hit for that linear address (user-accessible and writable). It then applies the user/supervisor check and the write-protect rule, and reports a page fault together with the access mode the fault claims. A segmentation fault takes priority and suppresses the paging check.

The segment descriptor fields, the translation buffer and the page attributes are all supplied by neighbouring logic. Encodings: access mode 0 = read, 1 = write, 2 = execute. Segment ids 0 to 5 are code/data segments. Ids 6 to 9 are system segments that are exempt from the null-selector check. Ids 10 to 15 are other system segments.

Top module: `acc_perm_chk`

## Requirements
- R1: Linear address and general-protection result are valid (`lin_valid`) one clock after `req_valid`. The paging result is valid (`chk_valid`) one clock after `lin_valid`. Both valids are 0 after reset, and each fault output is 0 whenever its valid is 0.
- R2: A set null-selector flag raises a general-protection fault for every segment id except 6, 7, 8 and 9.
- R3: For segment ids 0 to 5 only, a write (mode 1) or a store-check access to a non-writable segment faults, and a read (mode 0) of a non-readable segment faults. An execute access (mode 2) is not permission-checked.
- R4: The effective offset width is 8 * 2^code bits. The code comes from the alternate size code when the override is set and from the default code otherwise (code 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64).
- R5: The offset is (address - base) truncated to the effective width, and the end offset is offset + size - 1. A normal segment faults if either value is greater than the limit.
- R6: An expand-down segment faults if either the offset or the end offset is less than or equal to the limit.
- R7: The linear address equals the virtual address, with bits 63..32 cleared when the 64-bit-mode flag is 0 or the address-size override is 1.
- R8: User mode is privilege level 3 with the force-supervisor flag clear. A user-mode access to a page without user permission raises a page fault that reports the access's own mode.
- R9: A write is disallowed when the page is not writable and either user mode is active or the write-protect bit is set. A disallowed write (mode 1) raises a page fault.
- R10: A store-check access whose write would be disallowed raises a page fault that reports mode 1 (write), unless the user-page check of R8 already faults.
- R11: When the first step raises a general-protection fault, the second step still completes but reports no page fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| seg_id | input | 4 | Segment id (0-5 code/data, 6-9 exempt system, 10-15 other) |
| vaddr | input | 64 | Virtual address, segment base already applied |
| seg_base | input | 64 | Segment base |
| seg_limit | input | 64 | Segment limit |
| seg_readable | input | 1 | Segment readable attribute |
| seg_writable | input | 1 | Segment writable attribute |
| seg_expand_down | input | 1 | Expand-down segment |
| seg_null | input | 1 | Selector is null |
| acc_mode | input | 2 | 0 read, 1 write, 2 execute |
| store_probe | input | 1 | Store-check access |
| acc_size | input | 4 | Access size in bytes (1 or more) |
| addr_code_def | input | 2 | Default address-size code |
| addr_code_alt | input | 2 | Alternate address-size code |
| size_override | input | 1 | Address-size override |
| long_mode | input | 1 | 64-bit mode active |
| priv_level | input | 2 | Current privilege level |
| force_sup | input | 1 | Treat the access as supervisor |
| wp_bit | input | 1 | Write-protect control bit |
| pg_user | input | 1 | Hit page allows user access (sampled while lin_valid) |
| pg_writable | input | 1 | Hit page is writable (sampled while lin_valid) |
| lin_valid | output | 1 | First-step result valid |
| lin_addr | output | 64 | Linear address |
| gp_fault | output | 1 | General-protection fault |
| chk_valid | output | 1 | Second-step result valid |
| pf_fault | output | 1 | Page fault |
| pf_mode | output | 2 | Mode reported with the page fault |

## Verification
The assertions assume that the access size is never zero. They also assume that the page attributes are only meaningful in the cycle where `lin_valid` is high. The bench presents one access at a time: it drives a request for a single cycle and the page attributes in the next cycle. Every directed case uses a size of 1 to 4 bytes. Limits and bases are chosen so that the end-offset sum never wraps past 64 bits, which keeps the assumed input space intact.

// File: rtl/acc_chk_pkg.sv
// Package: shared encodings for the access permission checker.
// Assumes segment ids 0..DATA_SEG_CNT-1 are code/data segments and the
// exempt system segments occupy a contiguous id range.
package acc_chk_pkg;
    localparam int SEG_W        = 4;
    localparam int DATA_SEG_CNT = 6;
    localparam int EXEMPT_FIRST = 6;
    localparam int EXEMPT_CNT   = 4;
    localparam int CODE_W       = 2;
    localparam int SIZE_W       = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_mode_e;
endpackage

// File: rtl/seg_width_sel.sv
// Module: converts a log2 address-size code into an offset mask of
// 8 * 2^code ones, saturated at the address width.
// Assumes AW is at least 8.
module seg_width_sel #(
    parameter int AW     = 64,
    parameter int CODE_W = 2
) (
    input  logic [CODE_W-1:0] code,
    output logic [AW-1:0]     width_mask
);
    localparam int NCODE = 1 << CODE_W;

    logic [AW-1:0] masks [NCODE];

    // Build one constant mask per code value.
    for (genvar k = 0; k < NCODE; k++) begin : g_code
        for (genvar i = 0; i < AW; i++) begin : g_bit
            assign masks[k][i] = (i < (8 << k)) ? 1'b1 : 1'b0;
        end
    end

    // Select the mask for the requested code.
    assign width_mask = masks[code];
endmodule

// File: rtl/seg_stage.sv
// Module: first step. Applies selector, permission and limit checks,
// forms the linear address and registers it with the fault result and
// the context the paging step needs.
// Assumes acc_size is non-zero and offset + size does not wrap AW bits.
module seg_stage
    import acc_chk_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  seg_id,
    input  logic [AW-1:0]     vaddr,
    input  logic [AW-1:0]     seg_base,
    input  logic [AW-1:0]     seg_limit,
    input  logic              seg_readable,
    input  logic              seg_writable,
    input  logic              seg_expand_down,
    input  logic              seg_null,
    input  logic [1:0]        acc_mode,
    input  logic              store_probe,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [CODE_W-1:0] addr_code_def,
    input  logic [CODE_W-1:0] addr_code_alt,
    input  logic              size_override,
    input  logic              long_mode,
    input  logic [1:0]        priv_level,
    input  logic              force_sup,
    input  logic              wp_bit,
    output logic              lin_valid,
    output logic [AW-1:0]     lin_addr,
    output logic              gp_fault,
    output logic [1:0]        mode_q,
    output logic              store_q,
    output logic              user_q,
    output logic              wp_q
);
    localparam int EXEMPT_LAST = EXEMPT_FIRST + EXEMPT_CNT - 1;

    logic [CODE_W-1:0] eff_code;
    logic [AW-1:0]     width_mask;
    logic [AW-1:0]     lo32_mask;
    logic [AW-1:0]     offset;
    logic [AW-1:0]     end_off;
    logic [AW-1:0]     lin_next;
    logic              is_exempt;
    logic              is_data;
    logic              null_bad;
    logic              perm_bad;
    logic              lim_bad;
    logic              wants_write;

    // Pick the size code that sets the effective offset width.
    assign eff_code = size_override ? addr_code_alt : addr_code_def;

    seg_width_sel #(.AW(AW), .CODE_W(CODE_W)) i_width (
        .code       (eff_code),
        .width_mask (width_mask)
    );

    // Classify the segment id.
    always_comb begin
        is_exempt = (int'(seg_id) >= EXEMPT_FIRST) && (int'(seg_id) <= EXEMPT_LAST);
        is_data   = (int'(seg_id) < DATA_SEG_CNT);
    end

    // Null-selector and read/write permission checks.
    always_comb begin
        wants_write = (acc_mode == ACC_WRITE) || store_probe;
        null_bad    = seg_null && !is_exempt;
        perm_bad    = is_data &&
                      ((!seg_writable && wants_write) ||
                       (!seg_readable && (acc_mode == ACC_READ)));
    end

    // Two-ended limit check, sense inverted for expand-down segments.
    always_comb begin
        offset  = (vaddr - seg_base) & width_mask;
        end_off = offset + AW'(acc_size) - AW'(1);
        if (seg_expand_down)
            lim_bad = (offset <= seg_limit) || (end_off <= seg_limit);
        else
            lim_bad = (offset > seg_limit) || (end_off > seg_limit);
    end

    // Form the linear address, dropping the upper half outside 64-bit mode.
    always_comb begin
        for (int i = 0; i < AW; i++) lo32_mask[i] = (i < 32);
        lin_next = (long_mode && !size_override) ? vaddr : (vaddr & lo32_mask);
    end

    // Register the first-step result and the context for paging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_valid <= 1'b0;
            lin_addr  <= '0;
            gp_fault  <= 1'b0;
            mode_q    <= ACC_READ;
            store_q   <= 1'b0;
            user_q    <= 1'b0;
            wp_q      <= 1'b0;
        end else begin
            lin_valid <= req_valid;
            gp_fault  <= req_valid && (null_bad || perm_bad || lim_bad);
            if (req_valid) begin
                lin_addr <= lin_next;
                mode_q   <= acc_mode;
                store_q  <= store_probe;
                user_q   <= (priv_level == 2'd3) && !force_sup;
                wp_q     <= wp_bit;
            end
        end
    end

    // R2
    null_sel_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && seg_null && !is_exempt |=> gp_fault);

    // R1
    idle_no_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lin_valid |-> !gp_fault);

    // R6
    expdown_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && seg_expand_down && (vaddr == seg_base) |=> gp_fault);

    // R7
    if (AW > 32) begin : g_trunc_chk
        trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid && (!long_mode || size_override) |=> (lin_addr[AW-1:32] == '0));
    end
endmodule

// File: rtl/page_stage.sv
// Module: second step. Takes the page attributes of the translation hit
// for the registered linear address and applies the user/supervisor and
// write-protect rules. A first-step fault suppresses this check.
// Assumes pg_user / pg_writable are valid while lin_valid is high.
module page_stage
    import acc_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lin_valid,
    input  logic       gp_fault,
    input  logic [1:0] mode_q,
    input  logic       store_q,
    input  logic       user_q,
    input  logic       wp_q,
    input  logic       pg_user,
    input  logic       pg_writable,
    output logic       chk_valid,
    output logic       pf_fault,
    output logic [1:0] pf_mode
);
    logic user_bad;
    logic write_blocked;
    logic write_bad;
    logic probe_bad;

    // Evaluate the page rules for the current access.
    always_comb begin
        user_bad      = user_q && !pg_user;
        write_blocked = !pg_writable && (user_q || wp_q);
        write_bad     = (mode_q == ACC_WRITE) && write_blocked;
        probe_bad     = store_q && write_blocked;
    end

    // Register the paging verdict and the mode it reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_valid <= 1'b0;
            pf_fault  <= 1'b0;
            pf_mode   <= ACC_READ;
        end else begin
            chk_valid <= lin_valid;
            pf_fault  <= lin_valid && !gp_fault && (user_bad || write_bad || probe_bad);
            if (lin_valid) begin
                if (user_bad || write_bad)
                    pf_mode <= mode_q;
                else
                    pf_mode <= ACC_WRITE;
            end
        end
    end

    // R1
    stage_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lin_valid |=> chk_valid);

    // R1
    idle_no_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> !pf_fault);

    // R11
    gp_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lin_valid && gp_fault |=> !pf_fault);

    // R10
    probe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lin_valid && !gp_fault && store_q && !pg_writable && wp_q && (!user_q || pg_user)
        |=> pf_fault && (pf_mode == ACC_WRITE));

    // R9
    sup_nowp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lin_valid && (mode_q == ACC_WRITE) && !user_q && !wp_q && !store_q
        |=> !pf_fault);
endmodule

// File: rtl/acc_perm_chk.sv
// Module: top of the segment and page access permission checker.
// Chains the segmentation step and the paging step; the linear address
// leaves between them for an external translation lookup.
// Assumes one access per req_valid pulse and page attributes aligned to lin_valid.
module acc_perm_chk
    import acc_chk_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  seg_id,
    input  logic [AW-1:0]     vaddr,
    input  logic [AW-1:0]     seg_base,
    input  logic [AW-1:0]     seg_limit,
    input  logic              seg_readable,
    input  logic              seg_writable,
    input  logic              seg_expand_down,
    input  logic              seg_null,
    input  logic [1:0]        acc_mode,
    input  logic              store_probe,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [CODE_W-1:0] addr_code_def,
    input  logic [CODE_W-1:0] addr_code_alt,
    input  logic              size_override,
    input  logic              long_mode,
    input  logic [1:0]        priv_level,
    input  logic              force_sup,
    input  logic              wp_bit,
    input  logic              pg_user,
    input  logic              pg_writable,
    output logic              lin_valid,
    output logic [AW-1:0]     lin_addr,
    output logic              gp_fault,
    output logic              chk_valid,
    output logic              pf_fault,
    output logic [1:0]        pf_mode
);
    logic [1:0] mode_q;
    logic       store_q;
    logic       user_q;
    logic       wp_q;

    seg_stage #(.AW(AW)) i_seg (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .seg_id          (seg_id),
        .vaddr           (vaddr),
        .seg_base        (seg_base),
        .seg_limit       (seg_limit),
        .seg_readable    (seg_readable),
        .seg_writable    (seg_writable),
        .seg_expand_down (seg_expand_down),
        .seg_null        (seg_null),
        .acc_mode        (acc_mode),
        .store_probe     (store_probe),
        .acc_size        (acc_size),
        .addr_code_def   (addr_code_def),
        .addr_code_alt   (addr_code_alt),
        .size_override   (size_override),
        .long_mode       (long_mode),
        .priv_level      (priv_level),
        .force_sup       (force_sup),
        .wp_bit          (wp_bit),
        .lin_valid       (lin_valid),
        .lin_addr        (lin_addr),
        .gp_fault        (gp_fault),
        .mode_q          (mode_q),
        .store_q         (store_q),
        .user_q          (user_q),
        .wp_q            (wp_q)
    );

    page_stage i_page (
        .clk         (clk),
        .rst_n       (rst_n),
        .lin_valid   (lin_valid),
        .gp_fault    (gp_fault),
        .mode_q      (mode_q),
        .store_q     (store_q),
        .user_q      (user_q),
        .wp_q        (wp_q),
        .pg_user     (pg_user),
        .pg_writable (pg_writable),
        .chk_valid   (chk_valid),
        .pf_fault    (pf_fault),
        .pf_mode     (pf_mode)
    );
endmodule

// File: tb/test_acc_perm_chk.sv
// Directed bench for acc_perm_chk: one task per scenario.
module test_acc_perm_chk;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [3:0] seg_id;
    logic [AW-1:0] vaddr, seg_base, seg_limit;
    logic seg_readable, seg_writable, seg_expand_down, seg_null;
    logic [1:0] acc_mode;
    logic store_probe;
    logic [3:0] acc_size;
    logic [1:0] addr_code_def, addr_code_alt;
    logic size_override, long_mode;
    logic [1:0] priv_level;
    logic force_sup, wp_bit, pg_user, pg_writable;
    logic lin_valid, gp_fault, chk_valid, pf_fault;
    logic [AW-1:0] lin_addr;
    logic [1:0] pf_mode;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_perm_chk #(.AW(AW)) i_acc_perm_chk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .seg_id(seg_id),
        .vaddr(vaddr), .seg_base(seg_base), .seg_limit(seg_limit),
        .seg_readable(seg_readable), .seg_writable(seg_writable),
        .seg_expand_down(seg_expand_down), .seg_null(seg_null),
        .acc_mode(acc_mode), .store_probe(store_probe), .acc_size(acc_size),
        .addr_code_def(addr_code_def), .addr_code_alt(addr_code_alt),
        .size_override(size_override), .long_mode(long_mode),
        .priv_level(priv_level), .force_sup(force_sup), .wp_bit(wp_bit),
        .pg_user(pg_user), .pg_writable(pg_writable),
        .lin_valid(lin_valid), .lin_addr(lin_addr), .gp_fault(gp_fault),
        .chk_valid(chk_valid), .pf_fault(pf_fault), .pf_mode(pf_mode)
    );

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_defaults();
        seg_id = 4'd3; vaddr = 64'h1000; seg_base = '0; seg_limit = 64'hFFFF_FFFF;
        seg_readable = 1; seg_writable = 1; seg_expand_down = 0; seg_null = 0;
        acc_mode = 2'd0; store_probe = 0; acc_size = 4'd4;
        addr_code_def = 2'd2; addr_code_alt = 2'd1; size_override = 0; long_mode = 0;
        priv_level = 2'd0; force_sup = 0; wp_bit = 0; pg_user = 1; pg_writable = 1;
    endtask

    // Issue the staged access and check both steps against expectations.
    task automatic fire(input string req, input bit exp_gp, input bit exp_pf,
                        input logic [1:0] exp_mode);
        logic [AW-1:0] exp_lin;
        exp_lin = (long_mode && !size_override) ? vaddr : {32'h0, vaddr[31:0]};
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(lin_valid == 1'b1, {req, " lin_valid"}, AW'(lin_valid), 1);
        check(gp_fault == exp_gp, {req, " gp_fault"}, AW'(gp_fault), AW'(exp_gp));
        check(lin_addr == exp_lin, {req, " lin_addr"}, lin_addr, exp_lin);
        @(negedge clk);
        check(chk_valid == 1'b1, {req, " chk_valid"}, AW'(chk_valid), 1);
        check(pf_fault == exp_pf, {req, " pf_fault"}, AW'(pf_fault), AW'(exp_pf));
        if (exp_pf)
            check(pf_mode == exp_mode, {req, " pf_mode"}, AW'(pf_mode), AW'(exp_mode));
    endtask

    task automatic t_reset();
        check(lin_valid == 0 && chk_valid == 0 && gp_fault == 0 && pf_fault == 0,
              "R1 reset state", AW'({lin_valid, chk_valid, gp_fault, pf_fault}), 0);
        @(negedge clk);
        check(lin_valid == 0 && chk_valid == 0, "R1 idle stays idle",
              AW'({lin_valid, chk_valid}), 0);
    endtask

    task automatic t_basic();
        set_defaults(); seg_base = 64'h1000; vaddr = 64'h1010; seg_limit = 64'hFF;
        addr_code_def = 2'd1; priv_level = 2'd3;
        fire("R5 R1 in-range read", 0, 0, 0);
    endtask

    task automatic t_null();
        set_defaults(); seg_null = 1; seg_id = 4'd2;
        fire("R2 null data segment", 1, 0, 0);
        seg_id = 4'd7;
        fire("R2 null exempt id 7", 0, 0, 0);
        seg_id = 4'd12;
        fire("R2 null id 12", 1, 0, 0);
    endtask

    task automatic t_perm();
        set_defaults(); seg_id = 4'd1; seg_writable = 0; acc_mode = 2'd1;
        fire("R3 write non-writable", 1, 0, 0);
        acc_mode = 2'd0; store_probe = 1;
        fire("R3 store probe non-writable", 1, 0, 0);
        set_defaults(); seg_readable = 0;
        fire("R3 read non-readable", 1, 0, 0);
        acc_mode = 2'd2;
        fire("R3 execute not checked", 0, 0, 0);
        set_defaults(); seg_id = 4'd12; seg_writable = 0; acc_mode = 2'd1;
        fire("R3 system id not rw-checked", 0, 0, 0);
    endtask

    task automatic t_width();
        set_defaults(); seg_base = 64'h10000; vaddr = 64'h10; seg_limit = 64'h20;
        addr_code_def = 2'd1; addr_code_alt = 2'd2;
        fire("R4 16-bit offset wraps into range", 0, 0, 0);
        size_override = 1;
        fire("R4 alternate 32-bit offset out of range", 1, 0, 0);
    endtask

    task automatic t_limit();
        set_defaults(); seg_limit = 64'h100; vaddr = 64'h100; acc_size = 4'd1;
        fire("R5 offset equals limit", 0, 0, 0);
        acc_size = 4'd2;
        fire("R5 end offset past limit", 1, 0, 0);
    endtask

    task automatic t_expdown();
        set_defaults(); seg_expand_down = 1; seg_limit = 64'h100; vaddr = 64'h101;
        fire("R6 expand-down above limit", 0, 0, 0);
        vaddr = 64'h100;
        fire("R6 expand-down at limit", 1, 0, 0);
    endtask

    task automatic t_trunc();
        set_defaults(); long_mode = 1; addr_code_def = 2'd3; seg_limit = '1;
        vaddr = 64'h1234_5678_9ABC_DEF0;
        fire("R7 64-bit linear kept", 0, 0, 0);
        size_override = 1; addr_code_alt = 2'd2;
        fire("R7 override truncates", 0, 0, 0);
        check(lin_addr == 64'h9ABC_DEF0, "R7 truncated value", lin_addr, 64'h9ABC_DEF0);
    endtask

    task automatic t_user();
        set_defaults(); priv_level = 2'd3; pg_user = 0;
        fire("R8 user on supervisor page", 0, 1, 2'd0);
        force_sup = 1;
        fire("R8 force-supervisor passes", 0, 0, 0);
        force_sup = 0; priv_level = 2'd0;
        fire("R8 level 0 passes", 0, 0, 0);
    endtask

    task automatic t_write();
        set_defaults(); acc_mode = 2'd1; pg_writable = 0;
        fire("R9 supervisor write wp clear", 0, 0, 0);
        wp_bit = 1;
        fire("R9 supervisor write wp set", 0, 1, 2'd1);
        wp_bit = 0; priv_level = 2'd3;
        fire("R9 user write read-only page", 0, 1, 2'd1);
    endtask

    task automatic t_probe();
        set_defaults(); store_probe = 1; pg_writable = 0; wp_bit = 1;
        fire("R10 store probe reports write", 0, 1, 2'd1);
        priv_level = 2'd3; pg_user = 0;
        fire("R10 user violation reports own mode", 0, 1, 2'd0);
    endtask

    task automatic t_suppress();
        set_defaults(); seg_null = 1; priv_level = 2'd3; pg_user = 0;
        fire("R11 gp suppresses page fault", 1, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        set_defaults();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_null();
        t_perm();
        t_width();
        t_limit();
        t_expdown();
        t_trunc();
        t_user();
        t_write();
        t_probe();
        t_suppress();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule